// File: doc/BRIEF.md
# Tuner Control Bus Receiver

This block is a write-only slave receiver for a two-wire serial control bus running at up to 100 kHz. One physical bus port serves two device addresses. The first is a frequency synthesizer address, whose data loads a 15-bit divider word and a control/band register. The second is an offset-DAC address, whose data loads three sign-magnitude converter words and one shared step-size code. A two-bit board select input picks one of four address pairs. A single start-detected pulse is issued for every start condition on the bus, whether or not the address matches, so that a downstream divider can move its pending word into its working stage.

SCL and SDA are oversampled on a system clock of at least sixteen times the bus clock. Each line passes through a synchronizer. Start and stop are recognised as SDA edges while SCL is high. Acknowledges are given by pulling SDA low, and the pull-down output is active high. Synthesizer bytes are taken in pairs, and a pair only takes effect when its second byte completes. Each DAC byte carries its own target in its top two bits and takes effect as soon as it completes. In both sections at most four data bytes per transfer are taken and acknowledged.

Top module: `tuner_bus_rx`

## Requirements
- R1: An address byte 1100 S1 S0 A 0, where S1 S0 equals `addr_sel`, is acknowledged by holding `sda_pull` high through the ninth clock. A=0 selects the synthesizer section and A=1 selects the DAC section.
- R2: An address byte that does not match, including one with bit 0 set, gets no acknowledge. Data bytes after it are neither acknowledged nor loaded until the next start condition.
- R3: A synthesizer byte pair whose first byte has bit 7 = 0 sets `freq_word` to {first[6:0], second[7:0]}. It pulses `freq_load` for one cycle after the second byte.
- R4: A synthesizer pair whose first byte has bit 7 = 1 sets `ctrl_reg` to first[6:0] and `band_reg` to {second[7], second[5], second[3], second[1]}. It pulses `ctrl_load` once. A register changes only on its own strobe.
- R5: A third synthesizer data byte with no fourth changes nothing. A fourth byte completes a second pair, which is decoded by the bit 7 of the third byte.
- R6: In both sections, data bytes after the fourth get no acknowledge and load nothing.
- R7: In the DAC section, bits 7:6 of each byte select the target: 00, 01 and 10 address converters 1, 2 and 3. Bit 5 goes to `dac_sign` (1 means positive) and bits 4:0 go to that converter's 5-bit field of `dac_mag` (converter n at bits 5n-1:5n-5). The matching `dac_load` bit pulses once per byte. Any order and any repetition are accepted.
- R8: A DAC byte with bits 7:6 = 11 sets `range_code` to bits 1:0 and pulses `range_load`.
- R9: Every start condition, including a repeated start or one before a non-matching address, produces one `start_pulse`. A repeated start restarts the data-byte count.
- R10: After reset, `freq_word` is 256, every other register is 0, and no strobe or pull-down is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| addr_sel | input | 2 | Board address select, address bits 3:2 |
| sda_pull | output | 1 | High to pull SDA low (acknowledge) |
| start_pulse | output | 1 | One-cycle pulse per start condition |
| freq_word | output | 15 | Divider ratio word |
| freq_load | output | 1 | Frequency word update strobe |
| ctrl_reg | output | 7 | Control bits from first control byte |
| band_reg | output | 4 | Band outputs, MSB first |
| ctrl_load | output | 1 | Control/band update strobe |
| dac_sign | output | 3 | Offset sign per converter, bit n-1 for converter n |
| dac_mag | output | 15 | Offset magnitude, 5 bits per converter |
| dac_load | output | 3 | Per-converter update strobe |
| range_code | output | 2 | Shared step-size code |
| range_load | output | 1 | Step-size update strobe |

## Verification
The bench builds the block with its defaults: a two-flop synchronizer and a four-byte data limit. With these defaults the fifth-byte cut-off, the lone third byte and the repeated-start count reset can all be reached in short transfers. The bus is driven at 32 system clocks per bit, which leaves several cycles of slack after the synchronizer before the acknowledge is sampled. Strobe pulses are counted at the ports, so a duplicated or missing load shows up alongside the register values.

// File: rtl/tuner_bus_pkg.sv
package tuner_bus_pkg;

  localparam int BYTE_W   = 8;
  localparam int FREQ_W   = 15;
  localparam int CTRL_W   = 7;
  localparam int BAND_W   = 4;
  localparam int MAG_W    = 5;
  localparam int NUM_CONV = 3;
  localparam int RANGE_W  = 2;
  localparam logic [3:0] ADDR_PREFIX = 4'b1100;
  localparam logic [FREQ_W-1:0] FREQ_RESET = 15'd256;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_BITS,
    RX_ACK,
    RX_SKIP
  } rx_state_t;

  // Address byte: prefix, board select, section bit, write bit (0).
  function automatic logic addr_hit(input logic [7:0] b, input logic [1:0] sel);
    return (b[7:4] == ADDR_PREFIX) && (b[3:2] == sel) && (b[0] == 1'b0);
  endfunction

  function automatic logic [FREQ_W-1:0] freq_join(input logic [7:0] hi, input logic [7:0] lo);
    return {hi[6:0], lo};
  endfunction

  // Band bits sit on the odd positions of the second control byte.
  function automatic logic [BAND_W-1:0] band_pick(input logic [7:0] b);
    return {b[7], b[5], b[3], b[1]};
  endfunction

endpackage

// File: rtl/bus_line_cond.sv
module bus_line_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_sync;
  logic [SYNC_STAGES-1:0] sda_sync;
  logic scl_cur, sda_cur, scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_in};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
      scl_prev <= scl_cur;
      sda_prev <= sda_cur;
    end
  end

  assign scl_cur   = scl_sync[SYNC_STAGES-1];
  assign sda_cur   = sda_sync[SYNC_STAGES-1];
  assign sda_q     = sda_cur;
  assign scl_rise  = scl_cur & ~scl_prev;
  assign scl_fall  = ~scl_cur & scl_prev;
  assign start_det = scl_cur & scl_prev & sda_prev & ~sda_cur;
  assign stop_det  = scl_cur & scl_prev & ~sda_prev & sda_cur;

endmodule

// File: rtl/bus_byte_engine.sv
module bus_byte_engine
  import tuner_bus_pkg::*;
#(
  parameter int MAX_DATA = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_q,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [1:0] addr_sel,
  output logic       sda_pull,
  output logic       start_q,
  output logic       byte_stb,
  output logic       byte_odd,
  output logic       sect_dac,
  output logic [7:0] byte_val
);

  localparam int CNT_W = $clog2(MAX_DATA + 1);

  rx_state_t        state;
  logic [3:0]       bit_cnt;
  logic             in_addr;
  logic [CNT_W-1:0] data_cnt;
  logic [7:0]       shreg;
  logic             byte_full;
  logic             at_limit;

  assign byte_full = (bit_cnt == 4'd8);
  assign at_limit  = (data_cnt == CNT_W'(MAX_DATA));
  assign byte_val  = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RX_IDLE;
      bit_cnt  <= '0;
      in_addr  <= 1'b0;
      data_cnt <= '0;
      shreg    <= '0;
      sect_dac <= 1'b0;
      sda_pull <= 1'b0;
      byte_stb <= 1'b0;
      byte_odd <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      byte_stb <= 1'b0;
      start_q  <= start_det;
      if (start_det) begin
        state    <= RX_BITS;
        bit_cnt  <= '0;
        in_addr  <= 1'b1;
        data_cnt <= '0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        state    <= RX_IDLE;
        sda_pull <= 1'b0;
      end else begin
        unique case (state)
          RX_BITS: begin
            if (scl_rise && !byte_full) begin
              shreg   <= {shreg[6:0], sda_q};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && byte_full) begin
              bit_cnt <= '0;
              if (in_addr) begin
                in_addr <= 1'b0;
                if (addr_hit(shreg, addr_sel)) begin
                  sect_dac <= shreg[1];
                  sda_pull <= 1'b1;
                  state    <= RX_ACK;
                end else begin
                  state <= RX_SKIP;
                end
              end else begin
                byte_stb <= 1'b1;
                byte_odd <= data_cnt[0];
                data_cnt <= data_cnt + CNT_W'(1);
                sda_pull <= 1'b1;
                state    <= RX_ACK;
              end
            end
          end
          RX_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              state    <= at_limit ? RX_SKIP : RX_BITS;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: no acknowledge is driven while the receiver is parked.
  assert_parked_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == RX_IDLE) || (state == RX_SKIP)) |-> !sda_pull);

  // R9: a start condition always leaves the acknowledge released.
  assert_start_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> !sda_pull);

endmodule

// File: rtl/synth_latch.sv
module synth_latch
  import tuner_bus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic              odd,
  input  logic [7:0]        byte_val,
  output logic [FREQ_W-1:0] freq_word,
  output logic              freq_load,
  output logic [CTRL_W-1:0] ctrl_reg,
  output logic [BAND_W-1:0] band_reg,
  output logic              ctrl_load
);

  logic [7:0] first_q;
  logic       unused_pad;

  assign unused_pad = ^{byte_val[6], byte_val[4], byte_val[2], byte_val[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q   <= '0;
      freq_word <= FREQ_RESET;
      freq_load <= 1'b0;
      ctrl_reg  <= '0;
      band_reg  <= '0;
      ctrl_load <= 1'b0;
    end else begin
      freq_load <= 1'b0;
      ctrl_load <= 1'b0;
      if (stb && !odd) begin
        first_q <= byte_val;
      end else if (stb && odd) begin
        if (first_q[7]) begin
          ctrl_reg  <= first_q[6:0];
          band_reg  <= band_pick(byte_val);
          ctrl_load <= 1'b1;
        end else begin
          freq_word <= freq_join(first_q, byte_val);
          freq_load <= 1'b1;
        end
      end
    end
  end

  assert_freq_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !freq_load |-> $stable(freq_word));

  assert_ctrl_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_load |-> ($stable(ctrl_reg) && $stable(band_reg)));

  assert_one_pair_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(freq_load && ctrl_load));

endmodule

// File: rtl/offset_dac_latch.sv
module offset_dac_latch
  import tuner_bus_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      stb,
  input  logic [7:0]                byte_val,
  output logic [NUM_CONV-1:0]       dac_sign,
  output logic [NUM_CONV*MAG_W-1:0] dac_mag,
  output logic [NUM_CONV-1:0]       dac_load,
  output logic [RANGE_W-1:0]        range_code,
  output logic                      range_load
);

  logic [1:0] target;
  assign target = byte_val[7:6];

  for (genvar g = 0; g < NUM_CONV; g++) begin : g_conv
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dac_sign[g]               <= 1'b0;
        dac_mag[g*MAG_W +: MAG_W] <= '0;
        dac_load[g]               <= 1'b0;
      end else begin
        dac_load[g] <= 1'b0;
        if (stb && (target == 2'(g))) begin
          dac_sign[g]               <= byte_val[MAG_W];
          dac_mag[g*MAG_W +: MAG_W] <= byte_val[MAG_W-1:0];
          dac_load[g]               <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      range_code <= '0;
      range_load <= 1'b0;
    end else begin
      range_load <= 1'b0;
      if (stb && (target == 2'b11)) begin
        range_code <= byte_val[RANGE_W-1:0];
        range_load <= 1'b1;
      end
    end
  end

  assert_one_dac_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({range_load, dac_load}));

  assert_range_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !range_load |-> $stable(range_code));

endmodule

// File: rtl/tuner_bus_rx.sv
module tuner_bus_rx
  import tuner_bus_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MAX_DATA    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  input  logic [1:0]  addr_sel,
  output logic        sda_pull,
  output logic        start_pulse,
  output logic [14:0] freq_word,
  output logic        freq_load,
  output logic [6:0]  ctrl_reg,
  output logic [3:0]  band_reg,
  output logic        ctrl_load,
  output logic [2:0]  dac_sign,
  output logic [14:0] dac_mag,
  output logic [2:0]  dac_load,
  output logic [1:0]  range_code,
  output logic        range_load
);

  localparam int CNT_W = $clog2(MAX_DATA + 2);

  logic       sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic       byte_stb, byte_odd, sect_dac;
  logic [7:0] byte_val;
  logic       synth_stb, dac_stb;

  bus_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  bus_byte_engine #(.MAX_DATA(MAX_DATA)) u_engine (
    .clk(clk), .rst_n(rst_n), .sda_q(sda_q), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .addr_sel(addr_sel), .sda_pull(sda_pull), .start_q(start_pulse),
    .byte_stb(byte_stb), .byte_odd(byte_odd), .sect_dac(sect_dac),
    .byte_val(byte_val)
  );

  assign synth_stb = byte_stb & ~sect_dac;
  assign dac_stb   = byte_stb & sect_dac;

  synth_latch u_synth (
    .clk(clk), .rst_n(rst_n), .stb(synth_stb), .odd(byte_odd),
    .byte_val(byte_val), .freq_word(freq_word), .freq_load(freq_load),
    .ctrl_reg(ctrl_reg), .band_reg(band_reg), .ctrl_load(ctrl_load)
  );

  offset_dac_latch u_dac (
    .clk(clk), .rst_n(rst_n), .stb(dac_stb), .byte_val(byte_val),
    .dac_sign(dac_sign), .dac_mag(dac_mag), .dac_load(dac_load),
    .range_code(range_code), .range_load(range_load)
  );

  // Checker: data strobes between two start pulses never exceed the limit.
  logic [CNT_W-1:0] stb_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_seen <= '0;
    else if (start_pulse) stb_seen <= '0;
    else if (byte_stb && (stb_seen != CNT_W'(MAX_DATA + 1))) stb_seen <= stb_seen + CNT_W'(1);
  end

  assert_byte_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stb_seen <= CNT_W'(MAX_DATA));

endmodule

// File: tb/tuner_bus_rx_test.sv
`timescale 1ns/1ps
module tuner_bus_rx_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [1:0] addr_sel = 2'd0;
  logic sda_pull, start_pulse, freq_load, ctrl_load, range_load;
  logic [14:0] freq_word, dac_mag;
  logic [6:0] ctrl_reg;
  logic [3:0] band_reg;
  logic [2:0] dac_sign, dac_load;
  logic [1:0] range_code;
  logic sda_line;

  assign sda_line = sda_m & ~sda_pull;

  always #10 clk = ~clk;

  tuner_bus_rx uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .addr_sel(addr_sel), .sda_pull(sda_pull), .start_pulse(start_pulse),
    .freq_word(freq_word), .freq_load(freq_load), .ctrl_reg(ctrl_reg),
    .band_reg(band_reg), .ctrl_load(ctrl_load), .dac_sign(dac_sign),
    .dac_mag(dac_mag), .dac_load(dac_load), .range_code(range_code),
    .range_load(range_load)
  );

  int n_checks = 0;
  int n_fail = 0;
  int c_freq = 0, c_ctrl = 0, c_range = 0, c_start = 0;
  int c_dac0 = 0, c_dac1 = 0, c_dac2 = 0;
  bit finished = 0;

  always @(negedge clk) begin
    if (freq_load) c_freq++;
    if (ctrl_load) c_ctrl++;
    if (range_load) c_range++;
    if (start_pulse) c_start++;
    if (dac_load[0]) c_dac0++;
    if (dac_load[1]) c_dac1++;
    if (dac_load[2]) c_dac2++;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (8) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic send(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    acked = ~sda_line;
    wq(); scl_m = 1'b0; wq();
  endtask

  function automatic logic [7:0] adr(input logic [1:0] sel, input logic dac);
    return {4'b1100, sel, dac, 1'b0};
  endfunction

  task automatic t_reset();
    check("R10 freq_word", freq_word, 256);
    check("R10 ctrl_reg", ctrl_reg, 0);
    check("R10 band_reg", band_reg, 0);
    check("R10 dac_mag", dac_mag, 0);
    check("R10 dac_sign", dac_sign, 0);
    check("R10 range_code", range_code, 0);
    check("R10 sda_pull", sda_pull, 0);
  endtask

  task automatic t_freq_pair();
    bit a0, a1, a2;
    addr_sel = 2'd0;
    bus_start(); send(adr(2'd0, 1'b0), a0); send(8'h12, a1); send(8'h34, a2); bus_stop();
    check("R1 synth addr ack", a0, 1);
    check("R3 data acks", {a1, a2}, 2'b11);
    check("R3 freq_word", freq_word, 15'h1234);
    check("R3 freq_load count", c_freq, 1);
    check("R1 pull released", sda_pull, 0);
  endtask

  task automatic t_ctrl_pair();
    bit a0, a1, a2;
    addr_sel = 2'd2;
    bus_start(); send(adr(2'd2, 1'b0), a0); send(8'hD5, a1); send(8'hA8, a2); bus_stop();
    check("R1 select 2 ack", a0, 1);
    check("R4 ctrl_reg", ctrl_reg, 7'h55);
    check("R4 band_reg", band_reg, 4'b1110);
    check("R4 ctrl_load count", c_ctrl, 1);
    check("R4 freq untouched", freq_word, 15'h1234);
  endtask

  task automatic t_lone_third();
    bit a0, a1, a2, a3;
    bus_start(); send(adr(2'd2, 1'b0), a0); send(8'h01, a1); send(8'h00, a2);
    send(8'h82, a3); bus_stop();
    check("R5 third byte acked", a3, 1);
    check("R5 freq_word", freq_word, 15'h0100);
    check("R5 ctrl_reg kept", ctrl_reg, 7'h55);
    check("R5 ctrl_load unchanged", c_ctrl, 1);
    check("R5 freq_load count", c_freq, 2);
  endtask

  task automatic t_fifth_byte();
    bit a0, a1, a2, a3, a4, a5, a6;
    bus_start(); send(adr(2'd2, 1'b0), a0); send(8'h80, a1); send(8'h02, a2);
    send(8'h7F, a3); send(8'hFF, a4); send(8'h00, a5); send(8'h00, a6); bus_stop();
    check("R5 four acks", {a1, a2, a3, a4}, 4'hF);
    check("R6 fifth no ack", a5, 0);
    check("R6 sixth no ack", a6, 0);
    check("R6 freq_word", freq_word, 15'h7FFF);
    check("R5 band second pair", band_reg, 4'b0001);
    check("R5 ctrl_reg", ctrl_reg, 7'h00);
    check("R6 freq_load count", c_freq, 3);
  endtask

  task automatic t_mismatch();
    bit a0, a1, a2;
    int s0;
    s0 = c_start;
    bus_start(); send(adr(2'd0, 1'b0), a0); send(8'h00, a1); send(8'h00, a2); bus_stop();
    check("R2 wrong select no ack", a0, 0);
    check("R2 data no ack", {a1, a2}, 0);
    check("R2 freq kept", freq_word, 15'h7FFF);
    check("R9 start pulse on mismatch", c_start - s0, 1);
    bus_start(); send(8'hC9, a0); send(8'h00, a1); send(8'h00, a2); bus_stop();
    check("R2 read bit no ack", a0, 0);
    check("R2 freq kept after read addr", freq_word, 15'h7FFF);
    check("R2 band kept", band_reg, 4'b0001);
  endtask

  task automatic t_dac_all();
    bit a0, a1, a2, a3, a4;
    addr_sel = 2'd1;
    bus_start(); send(adr(2'd1, 1'b1), a0); send(8'h25, a1); send(8'h5F, a2);
    send(8'hA0, a3); send(8'hFE, a4); bus_stop();
    check("R1 dac addr ack", a0, 1);
    check("R7 data acks", {a1, a2, a3, a4}, 4'hF);
    check("R7 dac_sign", dac_sign, 3'b101);
    check("R7 dac_mag", dac_mag, {5'd0, 5'd31, 5'd5});
    check("R8 range_code", range_code, 2);
    check("R7 loads", c_dac0 * 100 + c_dac1 * 10 + c_dac2, 111);
    check("R8 range_load count", c_range, 1);
    check("R1 synth untouched by dac", freq_word, 15'h7FFF);
  endtask

  task automatic t_dac_repeat();
    bit a0, a1, a2, a3, a4, a5;
    bus_start(); send(adr(2'd1, 1'b1), a0); send(8'h01, a1); send(8'h02, a2);
    send(8'h03, a3); send(8'h04, a4); send(8'h3F, a5); bus_stop();
    check("R7 repeat acks", {a1, a2, a3, a4}, 4'hF);
    check("R6 dac fifth no ack", a5, 0);
    check("R7 conv1 last write", dac_mag[4:0], 4);
    check("R6 conv1 sign kept", dac_sign[0], 0);
    check("R7 conv1 load count", c_dac0, 5);
    check("R7 others kept", dac_mag[14:5], {5'd0, 5'd31});
  endtask

  task automatic t_restart();
    bit a0, a1, a2, b0, b1, b2, b3, b4;
    int s0;
    s0 = c_start;
    bus_start(); send(adr(2'd1, 1'b1), a0); send(8'h11, a1); send(8'h12, a2);
    bus_start(); send(adr(2'd1, 1'b1), b0); send(8'hC1, b1); send(8'h42, b2);
    send(8'h83, b3); send(8'h0A, b4); bus_stop();
    check("R9 start pulses", c_start - s0, 2);
    check("R9 restart acks", {b0, b1, b2, b3, b4}, 5'h1F);
    check("R9 conv1", dac_mag[4:0], 10);
    check("R9 conv2", dac_mag[9:5], 2);
    check("R9 conv3", dac_mag[14:10], 3);
    check("R9 signs", dac_sign, 3'b000);
    check("R8 range after restart", range_code, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_freq_pair();
    t_ctrl_pair();
    t_lone_third();
    t_fifth_byte();
    t_mismatch();
    t_dac_all();
    t_dac_repeat();
    t_restart();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule